// File: doc/BRIEF.md
# Bi-phase mark stereo audio transmitter

This block turns a stream of stereo 16-bit CD audio samples into consumer digital-audio subframes and drives them onto one serial line using bi-phase mark coding. Each 32-bit subframe holds a four-bit-time sync preamble, a 20-bit audio field, a validity bit, a user bit, a channel-status bit and an even parity bit. Left and right subframes alternate, and 384 subframes form one block. Channel status is generated on chip: it marks the stream as CD category, copies four Q-channel control bits and reports a 2-bit clock-accuracy setting.

The coder advances one half bit cell on each cycle in which `half_en_i` is high, so the bit-rate clock stays outside the block. At the start of every left subframe the block captures one left/right pair, either before concealment or after concealment as `mode_i` selects. It then pulses `pair_req_o` so that upstream logic can present the next pair. The user bit is sampled at the start of every subframe and carries the subcode Q-to-W stream, which is not aligned to blocks. A third mode holds the line low and parks the block position at the start of a block.

Top module: `bmc_audio_tx`

## Requirements
- R1: With `mode_i` = 00 the line is low from the cycle after that value is applied, and it stays low whatever `half_en_i` does. The block position returns to subframe 0, and the line level is taken as 0 when output resumes.
- R2: Subframe 0 of a block uses preamble B (half-cells 11101000, sent left to right). Other even-numbered subframes are left subframes and use M (11100010). Odd-numbered subframes are right subframes and use W (11100100). Each pattern is inverted when the line was high before the subframe began, and subframe 384 is again subframe 0.
- R3: Each `half_en_i` cycle emits one half-cell, and the line holds its level while `half_en_i` is low. For subframe bits 4 to 31 the line toggles at the start of every bit cell, and it toggles again mid-cell when the bit is 1.
- R4: Bits 4 to 11 are 0. Bits 12 to 27 carry the 16-bit two's complement sample, with its LSB at bit 12 and its MSB at bit 27.
- R5: `mode_i` = 01 selects the `raw_*` inputs and 10 or 11 selects the `cnc_*` inputs. The mode, both samples and both error flags are captured at the capture edge of a left subframe (a rising clock edge with `half_en_i` high that emits the subframe's first half-cell). The following right subframe uses the captured right data, whatever the inputs do after that edge.
- R6: Bit 28 equals the sample's error flag (1 means uncorrectable), whichever source is selected.
- R7: Bit 29 equals `user_bit_i` at the capture edge of that subframe.
- R8: Bit 30 is channel-status bit k, where k is the subframe index within the block divided by 2, so both subframes of a pair carry the same bit. Bits k=0..3 are `q_ctrl_i[k]`, bit 8 is 1, bit 28 is `clk_acc_i[1]`, bit 29 is `clk_acc_i[0]`, and every other bit is 0.
- R9: Bit 31 makes the number of ones in bits 4 to 31 even.
- R10: `pair_req_o` is high for exactly one cycle, in the cycle after the capture edge of each left subframe, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_en_i | input | 1 | Advance one half bit cell |
| mode_i | input | 2 | 00 line low, 01 pre-concealment data, 10/11 post-concealment data |
| raw_l_i | input | 16 | Left sample before concealment |
| raw_r_i | input | 16 | Right sample before concealment |
| cnc_l_i | input | 16 | Left sample after concealment |
| cnc_r_i | input | 16 | Right sample after concealment |
| err_l_i | input | 1 | Left sample uncorrectable |
| err_r_i | input | 1 | Right sample uncorrectable |
| user_bit_i | input | 1 | Subcode user-data bit |
| q_ctrl_i | input | 4 | Checked Q-channel control bits |
| clk_acc_i | input | 2 | Clock accuracy code |
| line_o | output | 1 | Bi-phase mark serial line |
| pair_req_o | output | 1 | Pair captured; present the next one |

## Verification
If the half-cell or bit counter slips, a preamble appears in the wrong place. Within one subframe (64 half-cells) this shows as a missing cell-edge transition or a wrong preamble pattern. If the subframe counter is wrong, the B preamble comes at a subframe other than 0 or 384, and a wrong pair index puts a nonzero channel-status bit into a slot that should be zero. Such errors show only once the affected pair index is reached, so the bench walks one full block and the block boundary after it. A stale right-sample store shows in the very next right subframe, because the bench changes the inputs after each left capture edge.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;
  localparam int SF_BITS  = 32;
  localparam int AUD_MSB  = 27;
  localparam int VAL_BIT  = 28;
  localparam int USR_BIT  = 29;
  localparam int CS_BIT   = 30;
  localparam int PAR_BIT  = 31;

  localparam logic [7:0] PAT_B = 8'b11101000;
  localparam logic [7:0] PAT_M = 8'b11100010;
  localparam logic [7:0] PAT_W = 8'b11100100;

  typedef enum logic [1:0] {SYN_B, SYN_M, SYN_W} sync_e;

  // channel-status bit k of a CD stream
  function automatic logic cs_bit(input int unsigned k, input logic [3:0] q,
                                  input logic [1:0] acc);
    if (k < 4)        return q[k[1:0]];
    else if (k == 8)  return 1'b1;
    else if (k == 28) return acc[1];
    else if (k == 29) return acc[0];
    else              return 1'b0;
  endfunction
endpackage

// File: rtl/bmc_seq.sv
module bmc_seq #(
  parameter int SF_PER_BLOCK = 384,
  localparam int IDX_W = $clog2(SF_PER_BLOCK)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    half_en_i,
  output logic                    half_o,
  output logic [4:0]              bit_o,
  output logic [IDX_W-1:0]        sf_o,
  output logic                    start_o,
  output logic                    left_o,
  output bmc_tx_pkg::sync_e       sync_o
);
  import bmc_tx_pkg::*;

  localparam logic [IDX_W-1:0] SF_LAST = IDX_W'(SF_PER_BLOCK - 1);

  logic             half_q;
  logic [4:0]       bit_q;
  logic [IDX_W-1:0] sf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      bit_q  <= '0;
      sf_q   <= '0;
    end else if (!run_i) begin
      half_q <= 1'b0;
      bit_q  <= '0;
      sf_q   <= '0;
    end else if (half_en_i) begin
      half_q <= ~half_q;
      if (half_q) begin
        bit_q <= bit_q + 5'd1;
        if (bit_q == 5'd31) sf_q <= (sf_q == SF_LAST) ? '0 : sf_q + 1'b1;
      end
    end
  end

  assign half_o  = half_q;
  assign bit_o   = bit_q;
  assign sf_o    = sf_q;
  assign left_o  = ~sf_q[0];
  assign start_o = run_i & half_en_i & ~half_q & (bit_q == 5'd0);

  always_comb begin
    if (sf_q == '0)    sync_o = SYN_B;
    else if (!sf_q[0]) sync_o = SYN_M;
    else               sync_o = SYN_W;
  end

  p_sf_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(sf_q) < SF_PER_BLOCK);
  p_park_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (sf_q == '0) && (bit_q == 5'd0) && !half_q);
endmodule

// File: rtl/bmc_frame.sv
module bmc_frame #(
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                left_i,
  input  logic [IDX_W-1:0]    sf_i,
  input  logic [1:0]          mode_i,
  input  logic [SAMPLE_W-1:0] raw_l_i,
  input  logic [SAMPLE_W-1:0] raw_r_i,
  input  logic [SAMPLE_W-1:0] cnc_l_i,
  input  logic [SAMPLE_W-1:0] cnc_r_i,
  input  logic                err_l_i,
  input  logic                err_r_i,
  input  logic                user_bit_i,
  input  logic [3:0]          q_ctrl_i,
  input  logic [1:0]          clk_acc_i,
  output logic [31:0]         word_o,
  output logic                pair_req_o
);
  import bmc_tx_pkg::*;

  logic [SAMPLE_W-1:0] r_hold_q;
  logic                r_err_q;
  logic [31:0]         word_q;
  logic                req_q;
  logic                use_raw;
  logic                cs_now;
  logic [IDX_W-1:0]    pair_idx;

  function automatic logic [31:0] build(input logic [SAMPLE_W-1:0] s, input logic e,
                                        input logic u, input logic c);
    logic [31:0] w;
    w = '0;
    w[AUD_MSB -: SAMPLE_W] = s;
    w[VAL_BIT] = e;
    w[USR_BIT] = u;
    w[CS_BIT]  = c;
    w[PAR_BIT] = ^w[CS_BIT:4];
    return w;
  endfunction

  assign use_raw  = (mode_i == 2'b01);
  assign pair_idx = sf_i >> 1;
  assign cs_now   = cs_bit(32'(pair_idx), q_ctrl_i, clk_acc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_hold_q <= '0;
      r_err_q  <= 1'b0;
      word_q   <= '0;
      req_q    <= 1'b0;
    end else begin
      req_q <= start_i & left_i;
      if (start_i) begin
        if (left_i) begin
          r_hold_q <= use_raw ? raw_r_i : cnc_r_i;
          r_err_q  <= err_r_i;
          word_q   <= build(use_raw ? raw_l_i : cnc_l_i, err_l_i, user_bit_i, cs_now);
        end else begin
          word_q   <= build(r_hold_q, r_err_q, user_bit_i, cs_now);
        end
      end
    end
  end

  assign word_o     = word_q;
  assign pair_req_o = req_q;

  p_parity_even_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (^word_o[31:4]) == 1'b0);
  p_req_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_req_o |=> !pair_req_o);
endmodule

// File: rtl/bmc_line.sv
module bmc_line (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              half_en_i,
  input  logic              half_i,
  input  logic [4:0]        bit_i,
  input  bmc_tx_pkg::sync_e sync_i,
  input  logic              data_bit_i,
  output logic              line_o
);
  import bmc_tx_pkg::*;

  logic       lvl_q, inv_q;
  logic [2:0] pidx;
  logic       in_pre;
  logic [7:0] pat;
  logic       inv_now;
  logic       pre_lvl;

  always_comb begin
    pidx   = {bit_i[1:0], half_i};
    in_pre = (bit_i < 5'd4);
    case (sync_i)
      SYN_B:   pat = PAT_B;
      SYN_M:   pat = PAT_M;
      default: pat = PAT_W;
    endcase
    inv_now = (pidx == 3'd0) ? lvl_q : inv_q;
    pre_lvl = pat[3'd7 - pidx] ^ inv_now;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      inv_q <= 1'b0;
    end else if (!run_i) begin
      lvl_q <= 1'b0;
      inv_q <= 1'b0;
    end else if (half_en_i) begin
      if (in_pre) begin
        lvl_q <= pre_lvl;
        if (pidx == 3'd0) inv_q <= lvl_q;
      end else if (!half_i) begin
        lvl_q <= ~lvl_q;
      end else begin
        lvl_q <= lvl_q ^ data_bit_i;
      end
    end
  end

  assign line_o = lvl_q;

  p_hold_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !line_o);
  p_cell_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && half_en_i && !in_pre && !half_i |=> line_o != $past(line_o));
  p_idle_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !half_en_i |=> $stable(line_o));
endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx #(
  parameter int SAMPLE_W     = 16,
  parameter int SF_PER_BLOCK = 384
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                half_en_i,
  input  logic [1:0]          mode_i,
  input  logic [SAMPLE_W-1:0] raw_l_i,
  input  logic [SAMPLE_W-1:0] raw_r_i,
  input  logic [SAMPLE_W-1:0] cnc_l_i,
  input  logic [SAMPLE_W-1:0] cnc_r_i,
  input  logic                err_l_i,
  input  logic                err_r_i,
  input  logic                user_bit_i,
  input  logic [3:0]          q_ctrl_i,
  input  logic [1:0]          clk_acc_i,
  output logic                line_o,
  output logic                pair_req_o
);
  import bmc_tx_pkg::*;

  localparam int IDX_W = $clog2(SF_PER_BLOCK);

  logic             run;
  logic             half;
  logic [4:0]       bit_pos;
  logic [IDX_W-1:0] sf;
  logic             start, left;
  sync_e            sync;
  logic [31:0]      word;

  assign run = (mode_i != 2'b00);

  bmc_seq #(.SF_PER_BLOCK(SF_PER_BLOCK)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .half_en_i(half_en_i),
    .half_o(half), .bit_o(bit_pos), .sf_o(sf), .start_o(start),
    .left_o(left), .sync_o(sync)
  );

  bmc_frame #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .left_i(left), .sf_i(sf),
    .mode_i(mode_i), .raw_l_i(raw_l_i), .raw_r_i(raw_r_i),
    .cnc_l_i(cnc_l_i), .cnc_r_i(cnc_r_i), .err_l_i(err_l_i), .err_r_i(err_r_i),
    .user_bit_i(user_bit_i), .q_ctrl_i(q_ctrl_i), .clk_acc_i(clk_acc_i),
    .word_o(word), .pair_req_o(pair_req_o)
  );

  bmc_line u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .half_en_i(half_en_i),
    .half_i(half), .bit_i(bit_pos), .sync_i(sync), .data_bit_i(word[bit_pos]),
    .line_o(line_o)
  );
endmodule

// File: tb/bmc_audio_tx_tb.sv
module bmc_audio_tx_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hen = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [15:0] raw_l = '0, raw_r = '0, cnc_l = '0, cnc_r = '0;
  logic err_l = 1'b0, err_r = 1'b0, ubit = 1'b0;
  logic [3:0] qc = 4'b0000;
  logic [1:0] acc = 2'b00;
  logic line_o, pair_req_o;

  int nvec = 0, nerr = 0, gapn = 0, bsf = 0;
  logic prev_lvl = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bmc_audio_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .half_en_i(hen), .mode_i(mode),
    .raw_l_i(raw_l), .raw_r_i(raw_r), .cnc_l_i(cnc_l), .cnc_r_i(cnc_r),
    .err_l_i(err_l), .err_r_i(err_r), .user_bit_i(ubit), .q_ctrl_i(qc),
    .clk_acc_i(acc), .line_o(line_o), .pair_req_o(pair_req_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic cs_exp(input int k, input logic [3:0] q, input logic [1:0] a);
    if (k < 4) return q[k];
    if (k == 8) return 1'b1;
    if (k == 28) return a[1];
    if (k == 29) return a[0];
    return 1'b0;
  endfunction

  task automatic half_cell(output logic lv, output logic rq);
    hen = 1'b1;
    @(negedge clk);
    lv = line_o;
    rq = pair_req_o;
    hen = 1'b0;
    for (int g = 0; g < gapn; g++) begin
      @(negedge clk);
      chk(line_o == lv, "R3 idle hold", 32'(line_o), 32'(lv));
    end
  endtask

  // capture one subframe and check every field
  task automatic do_sf(input logic [15:0] s, input logic e, input logic u);
    logic [63:0] h;
    logic rq0, rq, bad_req, edge_ok;
    logic [7:0] pre, exp_pat;
    logic [31:0] got, exp;
    logic csb;
    ubit = u;
    bad_req = 1'b0;
    for (int k = 0; k < 64; k++) begin
      half_cell(h[k], rq);
      if (k == 0) rq0 = rq;
      else if (rq) bad_req = 1'b1;
    end
    for (int k = 0; k < 8; k++) pre[7-k] = h[k] ^ prev_lvl;
    edge_ok = 1'b1;
    got = '0;
    for (int b = 4; b < 32; b++) begin
      if (h[2*b] == h[2*b-1]) edge_ok = 1'b0;
      got[b] = h[2*b] ^ h[2*b+1];
    end
    prev_lvl = h[63];
    exp_pat = (bsf == 0) ? 8'b11101000 : (bsf % 2 == 1) ? 8'b11100100 : 8'b11100010;
    csb = cs_exp(bsf / 2, qc, acc);
    exp = '0;
    exp[27:12] = s;
    exp[28] = e;
    exp[29] = u;
    exp[30] = csb;
    exp[31] = ^exp[30:4];
    chk(pre == exp_pat, "R2 preamble", 32'(pre), 32'(exp_pat));
    chk(edge_ok, "R3 cell edges", 32'(edge_ok), 32'd1);
    chk(got[27:4] == exp[27:4], "R4 audio field", got, exp);
    chk(got[28] == exp[28], "R6 validity", 32'(got[28]), 32'(exp[28]));
    chk(got[29] == exp[29], "R7 user bit", 32'(got[29]), 32'(exp[29]));
    chk(got[30] == exp[30], "R8 channel status", 32'(got[30]), 32'(exp[30]));
    chk(got[31] == exp[31], "R9 parity", 32'(got[31]), 32'(exp[31]));
    chk(rq0 == (bsf % 2 == 0) && !bad_req, "R10 pair request",
        {30'd0, bad_req, rq0}, 32'(bsf % 2 == 0));
    bsf = (bsf == 383) ? 0 : bsf + 1;
  endtask

  // raw pair (pl,pr) and concealed pair (cl,cr); the right data is checked after the inputs change
  task automatic send_pair(input logic [15:0] pl, pr, cl, cr, input logic el, er, ul, ur);
    logic sel_raw;
    raw_l = pl; raw_r = pr; cnc_l = cl; cnc_r = cr; err_l = el; err_r = er;
    sel_raw = (mode == 2'b01);
    do_sf(sel_raw ? pl : cl, el, ul);
    raw_l = ~pl; raw_r = ~pr; cnc_l = ~cl; cnc_r = ~cr; err_l = ~el; err_r = ~er;
    do_sf(sel_raw ? pr : cr, er, ur);  // R5 captured right data
  endtask

  task automatic t_reset();
    logic lv, rq;
    chk(line_o == 1'b0, "R1 reset line", 32'(line_o), 0);
    chk(pair_req_o == 1'b0, "R10 reset req", 32'(pair_req_o), 0);
    for (int i = 0; i < 6; i++) begin
      half_cell(lv, rq);
      chk(lv == 1'b0 && rq == 1'b0, "R1 held low", {30'd0, rq, lv}, 0);
    end
  endtask

  task automatic t_basic();
    mode = 2'b10; qc = 4'b0110; acc = 2'b01;
    send_pair(16'h1111, 16'h2222, 16'h1234, 16'hABCD, 1'b0, 1'b0, 1'b1, 1'b0);
    send_pair(16'h3333, 16'h4444, 16'h8000, 16'h7FFF, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_raw_select();
    mode = 2'b01;  // R5 pre-concealment source
    send_pair(16'h0F0F, 16'hF0F0, 16'h5555, 16'hAAAA, 1'b1, 1'b0, 1'b1, 1'b1);
    mode = 2'b11;  // R5 code 11 selects post
    send_pair(16'h0F0F, 16'hF0F0, 16'h5555, 16'hAAAA, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_validity();
    mode = 2'b10;  // R6 flag kept with concealed source
    send_pair(16'h0000, 16'h0000, 16'hFFFF, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_block();
    int n = 0;
    qc = 4'b1101; acc = 2'b10; mode = 2'b10;
    do begin
      send_pair(16'(n * 7), 16'(n * 13), 16'(n * 977 + 3), 16'(16'hC000 ^ (n * 31)),
                n[0], n[1], n[2], n[3]);
      n++;
    end while (bsf != 0);
    send_pair(16'h1357, 16'h2468, 16'h9BDF, 16'h0ACE, 1'b0, 1'b1, 1'b1, 1'b0);  // R2 B again
  endtask

  task automatic t_gap();
    gapn = 3;
    send_pair(16'h0102, 16'h0304, 16'hFEDC, 16'h0123, 1'b0, 1'b0, 1'b1, 1'b1);
    gapn = 0;
  endtask

  task automatic t_off();
    logic lv, rq;
    mode = 2'b00;
    @(negedge clk);
    chk(line_o == 1'b0, "R1 low after mode 00", 32'(line_o), 0);
    for (int i = 0; i < 5; i++) begin
      half_cell(lv, rq);
      chk(lv == 1'b0, "R1 stays low", 32'(lv), 0);
    end
    bsf = 0; prev_lvl = 1'b0;
    mode = 2'b10;  // R1 restart at block start
    send_pair(16'h4321, 16'h8765, 16'hDEAD, 16'hBEEF, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_raw_select();
    t_validity();
    t_gap();
    t_off();
    t_block();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule